// File: doc/BRIEF.md
# Complete-Split Response Handler

This block is the host-side decision logic for the complete-split phase of a periodic full- or low-speed transfer that goes through a high-speed hub's transaction translator. It holds the working copy of one queue head's transfer fields: the current byte offset, the bytes still to move, the data toggle, a 2-bit error counter and the bytes gathered so far in the current split. It also holds the complete-split progress mask, a frame tag and four status bits: active, halted, transaction error and split error.

A load strobe fills the working fields from a fetched queue head. After that, each response strobe carries the translator's reply: a response code, a received byte count, the data PID, the endpoint direction and a flag that says whether enough microframe time is left for a retry. On the clock edge that takes the strobe, the block updates the fields and reports one action for the scheduler. The action is to stay and issue another complete-split, to exit, to restart with a start-split at the next poll period, or to halt the queue. When the transfer has finished, it also gives a one-cycle pulse that tells the scheduler to retire the descriptor.

Top module: `csplit_resp_unit`

## Requirements
- R1: After reset every output is zero. A load strobe copies the offset, bytes-to-transfer, toggle and maximum packet length. The load also sets the error counter to 3 and active to 1, and clears halted, both error bits, the split byte count, the progress mask, the frame tag and the action code.
- R2: A NYET response (code 0) shifts a 1 into bit 0 of the progress mask and increments the frame tag. It changes no other field, leaves the error counter alone and reports action STAY (0).
- R3: A transaction error (code 1) sets the transaction-error status bit and decrements the error counter, which stays at zero once it is zero. If the result is non-zero and retry time remains, the action is STAY (0).
- R4: A transaction error whose decremented counter is zero gives action HALT (3). So does a transaction error on an IN endpoint with no retry time left. Every HALT sets halted and clears active.
- R5: A transaction error on an OUT endpoint with no retry time left and a non-zero decremented counter gives action RESTART (2).
- R6: An ACK (code 2) on an OUT endpoint moves the smaller of the maximum packet length and bytes-to-transfer. That amount is added to the offset and subtracted from bytes-to-transfer. The toggle flips, the error counter becomes 3 and the action is EXIT (1).
- R7: An MDATA response (code 3) on an IN endpoint adds the received byte count to the split byte count. The error counter is not changed and the action is STAY (0).
- R8: A DATA response (code 4) on an IN endpoint whose PID bit equals the toggle first adds the received count to the split byte count. The smaller of that sum and bytes-to-transfer is then added to the offset and subtracted from bytes-to-transfer. The toggle flips, the split count clears and the action is EXIT (1).
- R9: A DATA response on an IN endpoint whose PID bit differs from the toggle discards the split. The split byte count clears, the offset, bytes-to-transfer and toggle do not change, and the action is EXIT (1).
- R10: A NAK (code 5) sets the error counter to 3, does not advance the transfer and reports action EXIT (1).
- R11: An ERR response (code 6) sets the split-error status bit, decrements the error counter (it stays at zero once it is zero), does not advance the transfer and reports action EXIT (1).
- R12: A STALL (code 7) sets halted, clears active, leaves the transfer fields unchanged and reports action EXIT (1).
- R13: An ACK on an IN endpoint, or an MDATA or DATA response on an OUT endpoint, changes no field and reports action EXIT (1).
- R14: The action-valid output is high for exactly the one cycle after each response strobe. The retire pulse comes with it when an ACK or a matching DATA leaves bytes-to-transfer at zero. It also comes with a matching DATA whose total split byte count is below the maximum packet length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_valid | input | 1 | Load the working fields from a queue head |
| ld_offset | input | OFF_W | Offset to load |
| ld_bytes | input | BYTES_W | Bytes-to-transfer to load |
| ld_toggle | input | 1 | Data toggle to load |
| ld_mps | input | MPS_W | Maximum packet length to load |
| rsp_valid | input | 1 | A translator response is present |
| rsp_code | input | 3 | Response code: 0 NYET, 1 transaction error, 2 ACK, 3 MDATA, 4 DATA, 5 NAK, 6 ERR, 7 STALL |
| rsp_rx_bytes | input | SB_W | Bytes received with this response |
| rsp_pid | input | 1 | Data PID bit of the response (0 DATA0, 1 DATA1) |
| ep_is_in | input | 1 | Endpoint direction, 1 for IN |
| time_ok | input | 1 | Enough microframe time remains for a retry |
| cur_offset | output | OFF_W | Current byte offset |
| bytes_left | output | BYTES_W | Bytes still to transfer |
| toggle | output | 1 | Data toggle |
| cerr | output | 2 | Error counter |
| sbytes | output | SB_W | Bytes gathered in the current split |
| cprog | output | CP_W | Complete-split progress mask |
| ftag | output | FT_W | Frame tag |
| st_active | output | 1 | Active status |
| st_halted | output | 1 | Halted status |
| st_xact | output | 1 | Transaction-error status |
| st_err | output | 1 | Split-error status |
| act_valid | output | 1 | Action valid, one cycle per response |
| act_code | output | 2 | Action: 0 STAY, 1 EXIT, 2 RESTART, 3 HALT |
| retire | output | 1 | Retire-descriptor pulse |

## Verification
Every working field is a port, so a wrong internal update shows on the outputs one cycle after the response strobe that caused it. A counter decremented one step too far or reloaded at the wrong time shows at once on the error-counter port. The same fault shows again as a wrong HALT or RESTART on the next transaction error. A bad split byte count can stay hidden during a run of MDATA responses, but it shows at the latest on the DATA that ends the run: the offset, the remaining bytes and the retire pulse all come out wrong there.

// File: rtl/csplit_pkg.sv
package csplit_pkg;
    localparam int CERR_W = 2;
    localparam logic [CERR_W-1:0] CERR_MAX = '1;

    typedef enum logic [2:0] {
        RSP_NYET  = 3'd0,
        RSP_XACT  = 3'd1,
        RSP_ACK   = 3'd2,
        RSP_MDATA = 3'd3,
        RSP_DATA  = 3'd4,
        RSP_NAK   = 3'd5,
        RSP_ERR   = 3'd6,
        RSP_STALL = 3'd7
    } rsp_e;

    typedef enum logic [1:0] {
        ACT_STAY    = 2'd0,
        ACT_EXIT    = 2'd1,
        ACT_RESTART = 2'd2,
        ACT_HALT    = 2'd3
    } act_e;
endpackage

// File: rtl/csplit_decide.sv
module csplit_decide
    import csplit_pkg::*;
(
    input  rsp_e              code,
    input  logic [CERR_W-1:0] cerr_q,
    input  logic              dir_in,
    input  logic              time_ok,
    output logic [CERR_W-1:0] cerr_d,
    output act_e              act,
    output logic              set_xact,
    output logic              set_err,
    output logic              set_halt,
    output logic              do_nyet,
    output logic              do_ack,
    output logic              do_mdata,
    output logic              do_data
);
    logic [CERR_W-1:0] cerr_dec;

    always_comb begin
        cerr_dec = (cerr_q == '0) ? '0 : cerr_q - 1'b1;
        cerr_d   = cerr_q;
        act      = ACT_EXIT;
        set_xact = 1'b0;
        set_err  = 1'b0;
        set_halt = 1'b0;
        do_nyet  = 1'b0;
        do_ack   = 1'b0;
        do_mdata = 1'b0;
        do_data  = 1'b0;
        unique case (code)
            RSP_NYET: begin
                do_nyet = 1'b1;
                act     = ACT_STAY;
            end
            RSP_XACT: begin
                set_xact = 1'b1;
                cerr_d   = cerr_dec;
                if (cerr_dec == '0) begin
                    act = ACT_HALT;
                end else if (!time_ok) begin
                    act = dir_in ? ACT_HALT : ACT_RESTART;
                end else begin
                    act = ACT_STAY;
                end
                set_halt = (act == ACT_HALT);
            end
            RSP_ACK: begin
                if (!dir_in) begin
                    do_ack = 1'b1;
                    cerr_d = CERR_MAX;
                end
            end
            RSP_MDATA: begin
                if (dir_in) begin
                    do_mdata = 1'b1;
                    act      = ACT_STAY;
                end
            end
            RSP_DATA: begin
                do_data = dir_in;
            end
            RSP_NAK: begin
                cerr_d = CERR_MAX;
            end
            RSP_ERR: begin
                set_err = 1'b1;
                cerr_d  = cerr_dec;
            end
            RSP_STALL: begin
                set_halt = 1'b1;
            end
            default: act = ACT_EXIT;
        endcase
    end
endmodule

// File: rtl/csplit_advance.sv
module csplit_advance #(
    parameter int OFF_W   = 15,
    parameter int BYTES_W = 15,
    parameter int CAP_W   = 11
) (
    input  logic [OFF_W-1:0]   off,
    input  logic [BYTES_W-1:0] bytes,
    input  logic [CAP_W-1:0]   cap,
    output logic [OFF_W-1:0]   off_nx,
    output logic [BYTES_W-1:0] bytes_nx,
    output logic               last
);
    logic [BYTES_W-1:0] cap_x;
    logic [BYTES_W-1:0] amt;

    always_comb begin
        cap_x    = BYTES_W'(cap);
        amt      = (cap_x < bytes) ? cap_x : bytes;
        off_nx   = off + OFF_W'(amt);
        bytes_nx = bytes - amt;
        last     = (bytes_nx == '0);
    end
endmodule

// File: rtl/csplit_resp_unit.sv
module csplit_resp_unit
    import csplit_pkg::*;
#(
    parameter int OFF_W   = 15,
    parameter int BYTES_W = 15,
    parameter int MPS_W   = 11,
    parameter int SB_W    = 11,
    parameter int CP_W    = 8,
    parameter int FT_W    = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ld_valid,
    input  logic [OFF_W-1:0]   ld_offset,
    input  logic [BYTES_W-1:0] ld_bytes,
    input  logic               ld_toggle,
    input  logic [MPS_W-1:0]   ld_mps,
    input  logic               rsp_valid,
    input  logic [2:0]         rsp_code,
    input  logic [SB_W-1:0]    rsp_rx_bytes,
    input  logic               rsp_pid,
    input  logic               ep_is_in,
    input  logic               time_ok,
    output logic [OFF_W-1:0]   cur_offset,
    output logic [BYTES_W-1:0] bytes_left,
    output logic               toggle,
    output logic [CERR_W-1:0]  cerr,
    output logic [SB_W-1:0]    sbytes,
    output logic [CP_W-1:0]    cprog,
    output logic [FT_W-1:0]    ftag,
    output logic               st_active,
    output logic               st_halted,
    output logic               st_xact,
    output logic               st_err,
    output logic               act_valid,
    output logic [1:0]         act_code,
    output logic               retire
);
    typedef struct packed {
        logic [OFF_W-1:0]   off;
        logic [BYTES_W-1:0] bytes;
        logic               tog;
        logic [CERR_W-1:0]  cerr;
        logic [SB_W-1:0]    sb;
        logic [MPS_W-1:0]   mps;
        logic [CP_W-1:0]    cprog;
        logic [FT_W-1:0]    ftag;
        logic               active;
        logic               halted;
        logic               xact;
        logic               err;
        logic               avalid;
        act_e               act;
        logic               retire;
    } state_t;

    state_t s_q, s_d;

    logic [CERR_W-1:0]  cerr_nx;
    act_e               act_nx;
    logic               set_xact, set_err, set_halt;
    logic               do_nyet, do_ack, do_mdata, do_data;
    logic [SB_W-1:0]    sb_acc;
    logic [OFF_W-1:0]   ack_off, dat_off;
    logic [BYTES_W-1:0] ack_bytes, dat_bytes;
    logic               ack_last, dat_last;

    assign sb_acc = s_q.sb + rsp_rx_bytes;

    csplit_decide dec_i (
        .code     (rsp_e'(rsp_code)),
        .cerr_q   (s_q.cerr),
        .dir_in   (ep_is_in),
        .time_ok  (time_ok),
        .cerr_d   (cerr_nx),
        .act      (act_nx),
        .set_xact (set_xact),
        .set_err  (set_err),
        .set_halt (set_halt),
        .do_nyet  (do_nyet),
        .do_ack   (do_ack),
        .do_mdata (do_mdata),
        .do_data  (do_data)
    );

    csplit_advance #(.OFF_W(OFF_W), .BYTES_W(BYTES_W), .CAP_W(MPS_W)) adv_ack_i (
        .off      (s_q.off),
        .bytes    (s_q.bytes),
        .cap      (s_q.mps),
        .off_nx   (ack_off),
        .bytes_nx (ack_bytes),
        .last     (ack_last)
    );

    csplit_advance #(.OFF_W(OFF_W), .BYTES_W(BYTES_W), .CAP_W(SB_W)) adv_dat_i (
        .off      (s_q.off),
        .bytes    (s_q.bytes),
        .cap      (sb_acc),
        .off_nx   (dat_off),
        .bytes_nx (dat_bytes),
        .last     (dat_last)
    );

    always_comb begin
        s_d        = s_q;
        s_d.avalid = 1'b0;
        s_d.retire = 1'b0;
        if (ld_valid) begin
            s_d.off    = ld_offset;
            s_d.bytes  = ld_bytes;
            s_d.tog    = ld_toggle;
            s_d.mps    = ld_mps;
            s_d.cerr   = CERR_MAX;
            s_d.sb     = '0;
            s_d.cprog  = '0;
            s_d.ftag   = '0;
            s_d.active = 1'b1;
            s_d.halted = 1'b0;
            s_d.xact   = 1'b0;
            s_d.err    = 1'b0;
            s_d.act    = ACT_STAY;
        end else if (rsp_valid) begin
            s_d.avalid = 1'b1;
            s_d.act    = act_nx;
            s_d.cerr   = cerr_nx;
            if (set_xact) s_d.xact = 1'b1;
            if (set_err)  s_d.err  = 1'b1;
            if (set_halt) begin
                s_d.halted = 1'b1;
                s_d.active = 1'b0;
            end
            if (do_nyet) begin
                s_d.cprog = {s_q.cprog[CP_W-2:0], 1'b1};
                s_d.ftag  = s_q.ftag + 1'b1;
            end
            if (do_ack) begin
                s_d.off    = ack_off;
                s_d.bytes  = ack_bytes;
                s_d.tog    = ~s_q.tog;
                s_d.retire = ack_last;
            end
            if (do_mdata) begin
                s_d.sb = sb_acc;
            end
            if (do_data) begin
                s_d.sb = '0;
                if (rsp_pid == s_q.tog) begin
                    s_d.off    = dat_off;
                    s_d.bytes  = dat_bytes;
                    s_d.tog    = ~s_q.tog;
                    s_d.retire = dat_last || (MPS_W'(sb_acc) < s_q.mps);
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign cur_offset = s_q.off;
    assign bytes_left = s_q.bytes;
    assign toggle     = s_q.tog;
    assign cerr       = s_q.cerr;
    assign sbytes     = s_q.sb;
    assign cprog      = s_q.cprog;
    assign ftag       = s_q.ftag;
    assign st_active  = s_q.active;
    assign st_halted  = s_q.halted;
    assign st_xact    = s_q.xact;
    assign st_err     = s_q.err;
    assign act_valid  = s_q.avalid;
    assign act_code   = s_q.act;
    assign retire     = s_q.retire;
endmodule

// File: rtl/csplit_resp_chk.sv
module csplit_resp_chk #(
    parameter int OFF_W   = 15,
    parameter int BYTES_W = 15
) (
    input logic               clk,
    input logic               rst_n,
    input logic               ld_valid,
    input logic               rsp_valid,
    input logic [2:0]         rsp_code,
    input logic               ep_is_in,
    input logic [OFF_W-1:0]   cur_offset,
    input logic [BYTES_W-1:0] bytes_left,
    input logic [1:0]         cerr,
    input logic               st_xact,
    input logic               st_halted,
    input logic               st_active,
    input logic               act_valid,
    input logic [1:0]         act_code,
    input logic               retire
);
    AST_NYET_HOLDS_XFER: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !ld_valid && rsp_code == 3'd0) |=> ($stable(cur_offset) && $stable(bytes_left) && $stable(cerr))); // R2

    AST_XACT_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !ld_valid && rsp_code == 3'd1) |=> st_xact); // R3

    AST_HALT_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        (act_valid && act_code == 2'd3) |-> (st_halted && !st_active)); // R4

    AST_ACK_RELOADS_CERR: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !ld_valid && rsp_code == 3'd2 && !ep_is_in) |=> (cerr == 2'd3)); // R6

    AST_NAK_RELOADS_CERR: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !ld_valid && rsp_code == 3'd5) |=> (cerr == 2'd3)); // R10

    AST_ACT_FOLLOWS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !ld_valid) |=> act_valid); // R14

    AST_RETIRE_IN_ACT: assert property (@(posedge clk) disable iff (!rst_n)
        retire |-> act_valid); // R14
endmodule

bind csplit_resp_unit csplit_resp_chk #(.OFF_W(OFF_W), .BYTES_W(BYTES_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .ld_valid   (ld_valid),
    .rsp_valid  (rsp_valid),
    .rsp_code   (rsp_code),
    .ep_is_in   (ep_is_in),
    .cur_offset (cur_offset),
    .bytes_left (bytes_left),
    .cerr       (cerr),
    .st_xact    (st_xact),
    .st_halted  (st_halted),
    .st_active  (st_active),
    .act_valid  (act_valid),
    .act_code   (act_code),
    .retire     (retire)
);

// File: tb/csplit_resp_unit_tb.sv
module csplit_resp_unit_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int VW = 15 + 15 + 1 + 2 + 11 + 8 + 5 + 4 + 1 + 2 + 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ld_valid = 1'b0;
    logic [14:0] ld_offset = '0;
    logic [14:0] ld_bytes = '0;
    logic        ld_toggle = 1'b0;
    logic [10:0] ld_mps = '0;
    logic        rsp_valid = 1'b0;
    logic [2:0]  rsp_code = '0;
    logic [10:0] rsp_rx_bytes = '0;
    logic        rsp_pid = 1'b0;
    logic        ep_is_in = 1'b0;
    logic        time_ok = 1'b1;
    logic [14:0] cur_offset, bytes_left;
    logic        toggle;
    logic [1:0]  cerr;
    logic [10:0] sbytes;
    logic [7:0]  cprog;
    logic [4:0]  ftag;
    logic        st_active, st_halted, st_xact, st_err, act_valid, retire;
    logic [1:0]  act_code;

    int n_checks = 0;
    int n_fail = 0;

    logic [14:0] m_off, m_bytes;
    logic        m_tog;
    logic [1:0]  m_cerr;
    logic [10:0] m_sb, m_mps;
    logic [7:0]  m_cprog;
    logic [4:0]  m_ftag;
    logic        m_act, m_halt, m_xact, m_err, m_av, m_ret;
    logic [1:0]  m_code;

    always #(CLK_PERIOD/2) clk = ~clk;

    csplit_resp_unit dut_i (
        .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_offset(ld_offset),
        .ld_bytes(ld_bytes), .ld_toggle(ld_toggle), .ld_mps(ld_mps),
        .rsp_valid(rsp_valid), .rsp_code(rsp_code), .rsp_rx_bytes(rsp_rx_bytes),
        .rsp_pid(rsp_pid), .ep_is_in(ep_is_in), .time_ok(time_ok),
        .cur_offset(cur_offset), .bytes_left(bytes_left), .toggle(toggle),
        .cerr(cerr), .sbytes(sbytes), .cprog(cprog), .ftag(ftag),
        .st_active(st_active), .st_halted(st_halted), .st_xact(st_xact),
        .st_err(st_err), .act_valid(act_valid), .act_code(act_code), .retire(retire)
    );

    function automatic logic [VW-1:0] got_vec();
        return {cur_offset, bytes_left, toggle, cerr, sbytes, cprog, ftag,
                st_active, st_halted, st_xact, st_err, act_valid, act_code, retire};
    endfunction

    function automatic logic [VW-1:0] exp_vec();
        return {m_off, m_bytes, m_tog, m_cerr, m_sb, m_cprog, m_ftag,
                m_act, m_halt, m_xact, m_err, m_av, m_code, m_ret};
    endfunction

    function automatic string tag_of(logic [2:0] c, logic in_ep);
        case (c)
            3'd0: return "R2";
            3'd1: return (m_code == 2'd3) ? "R4" : (m_code == 2'd2) ? "R5" : "R3";
            3'd2: return in_ep ? "R13" : (m_ret ? "R14" : "R6");
            3'd3: return in_ep ? "R7" : "R13";
            3'd4: return !in_ep ? "R13" : (rsp_pid == m_tog) ? "R9" : "R8";
            3'd5: return "R10";
            3'd6: return "R11";
            default: return "R12";
        endcase
    endfunction

    task automatic check(string tag);
        n_checks++;
        if (got_vec() !== exp_vec()) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, got_vec(), exp_vec());
        end
    endtask

    task automatic model_reset();
        m_off = '0; m_bytes = '0; m_tog = 0; m_cerr = '0; m_sb = '0; m_mps = '0;
        m_cprog = '0; m_ftag = '0; m_act = 0; m_halt = 0; m_xact = 0; m_err = 0;
        m_av = 0; m_ret = 0; m_code = 2'd0;
    endtask

    task automatic do_load(int off, int bytes, bit tog, int mps, bit in_ep);
        @(negedge clk);
        ld_valid = 1; ld_offset = 15'(off); ld_bytes = 15'(bytes);
        ld_toggle = tog; ld_mps = 11'(mps); ep_is_in = in_ep;
        @(negedge clk);
        ld_valid = 0;
        m_off = 15'(off); m_bytes = 15'(bytes); m_tog = tog; m_mps = 11'(mps);
        m_cerr = 2'd3; m_sb = '0; m_cprog = '0; m_ftag = '0; m_act = 1;
        m_halt = 0; m_xact = 0; m_err = 0; m_av = 0; m_ret = 0; m_code = 2'd0;
        check("R1");
    endtask

    task automatic model_rsp(logic [2:0] c, int rx, bit pid, bit in_ep, bit tok);
        int dec, n, acc;
        dec = (m_cerr == 0) ? 0 : int'(m_cerr) - 1;
        m_av = 1; m_ret = 0; m_code = 2'd1;
        case (c)
            3'd0: begin m_cprog = {m_cprog[6:0], 1'b1}; m_ftag = m_ftag + 1; m_code = 2'd0; end
            3'd1: begin
                m_cerr = 2'(dec); m_xact = 1;
                if (dec == 0) m_code = 2'd3;
                else if (!tok) m_code = in_ep ? 2'd3 : 2'd2;
                else m_code = 2'd0;
                if (m_code == 2'd3) begin m_halt = 1; m_act = 0; end
            end
            3'd2: if (!in_ep) begin
                n = (int'(m_mps) < int'(m_bytes)) ? int'(m_mps) : int'(m_bytes);
                m_off = 15'(int'(m_off) + n); m_bytes = 15'(int'(m_bytes) - n);
                m_tog = ~m_tog; m_cerr = 2'd3; m_ret = (m_bytes == 0);
            end
            3'd3: if (in_ep) begin m_sb = 11'(int'(m_sb) + rx); m_code = 2'd0; end
            3'd4: if (in_ep) begin
                acc = (int'(m_sb) + rx) % 2048;
                if (pid == m_tog) begin
                    n = (acc < int'(m_bytes)) ? acc : int'(m_bytes);
                    m_off = 15'(int'(m_off) + n); m_bytes = 15'(int'(m_bytes) - n);
                    m_tog = ~m_tog; m_ret = (m_bytes == 0) || (acc < int'(m_mps));
                end
                m_sb = '0;
            end
            3'd5: m_cerr = 2'd3;
            3'd6: begin m_err = 1; m_cerr = 2'(dec); end
            default: begin m_halt = 1; m_act = 0; end
        endcase
    endtask

    task automatic do_rsp(logic [2:0] c, int rx, bit pid, bit tok);
        @(negedge clk);
        rsp_valid = 1; rsp_code = c; rsp_rx_bytes = 11'(rx); rsp_pid = pid; time_ok = tok;
        model_rsp(c, rx, pid, ep_is_in, tok);
        @(negedge clk);
        rsp_valid = 0;
        check(tag_of(c, ep_is_in));
        m_av = 0; m_ret = 0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_c0de));
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check("R1");

        // OUT endpoint: transaction errors with time left, counting down to halt
        do_load(100, 100, 0, 64, 0);
        do_rsp(3'd1, 0, 0, 1);   // R3 counter 3->2 stay
        do_rsp(3'd0, 0, 0, 1);   // R2 NYET
        do_rsp(3'd1, 0, 0, 1);   // R3 2->1
        do_rsp(3'd1, 0, 0, 1);   // R4 1->0 halt
        do_rsp(3'd1, 0, 0, 1);   // R3 stays zero, halt again
        // R5: OUT, no time, counter non-zero
        do_load(0, 100, 0, 64, 0);
        do_rsp(3'd1, 0, 0, 0);
        // R6 / R14: ACK twice, second drains to zero
        do_load(0, 100, 1, 64, 0);
        do_rsp(3'd2, 0, 0, 1);
        do_rsp(3'd2, 0, 0, 1);
        @(negedge clk);
        check("R14");            // pulses gone one cycle later
        // R13: MDATA and DATA on OUT ignored
        do_rsp(3'd3, 20, 0, 1);
        do_rsp(3'd4, 20, 0, 1);
        // R4 IN without time; R7/R8 MDATA then matching DATA
        do_load(8, 300, 0, 64, 1);
        do_rsp(3'd1, 0, 0, 0);
        do_load(8, 300, 0, 64, 1);
        do_rsp(3'd3, 40, 0, 1);
        do_rsp(3'd3, 40, 0, 1);
        do_rsp(3'd4, 10, 0, 1);  // R8 full-size: 90 moved, no short
        do_rsp(3'd3, 30, 0, 1);
        do_rsp(3'd4, 5, 0, 1);   // R9 wrong PID
        do_rsp(3'd4, 5, 1, 1);   // R8 short packet, R14 retire
        do_rsp(3'd2, 0, 0, 1);   // R13 ACK on IN
        do_rsp(3'd6, 0, 0, 1);   // R11
        do_rsp(3'd6, 0, 0, 1);   // R11
        do_rsp(3'd5, 0, 0, 1);   // R10
        do_rsp(3'd7, 0, 0, 1);   // R12

        for (int i = 0; i < 1500; i++) begin
            if (i % 6 == 0)
                do_load(int'($urandom % 4096), int'($urandom % 2500), 1'($urandom),
                        1 + int'($urandom % 1023), 1'($urandom));
            do_rsp(3'($urandom), int'($urandom % 200), 1'($urandom), ($urandom % 4) != 0);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule